// File: doc/BRIEF.md
# Sub-sample zero-crossing tracker

This block follows the third positive zero crossing of a repeating radio pulse inside a capture window of already band-pass filtered, averaged samples spaced 1 us apart. Each time it is started it looks at a small neighbourhood around its current tracking point and picks the sample whose magnitude is smallest. That sample becomes the new tracking point. The block then refines the crossing time below one sample. It divides the value at that point by the difference between its two neighbours. It then turns the quotient into a nanosecond offset through a correction table, which the surrounding system loads over a write port.

The tracking point has a home position at sample 75 and may drift up to ten samples either way. If it drifts further, the block reports a signed shift in samples. The window owner moves the capture window by that shift, and the next search is centred on the home position again. A zero neighbour difference makes the quotient meaningless. In that case the block flags the result as invalid and keeps the previous offset.

Top module: `zc_tracker`

## Requirements
- R1: After reset, done_o, shift_o, offset_o, invalid_o and realign_o are 0, idx_o is 75, and the first search is centred on sample 75.
- R2: A run picks the sample with the smallest absolute value among indices T-4 to T+4, where T is the current tracking point, limited to the range 1 to 158. On equal magnitudes the lowest index wins, and the pick appears on idx_o.
- R3: With Fb, Fn and Fa the samples at idx-1, idx and idx+1, the quotient is q = trunc(Fn*4096/(Fa-Fb)) toward zero, limited to the range -4096 to +4096.
- R4: The table index is 574 + floor(q*1820/4096), limited to 0..1110. offset_o then equals the signed 16-bit table entry last written at that index through tbl_we_i, tbl_addr_i and tbl_data_i.
- R5: When idx-75 exceeds +10 or is below -10, realign_o is 1, shift_o equals idx-75, and the next search is centred on 75.
- R6: When idx-75 lies within -10..+10, realign_o is 0, shift_o is 0, and the next search is centred on idx.
- R7: When Fa equals Fb, invalid_o is 1 and offset_o keeps its previous value, while idx_o, shift_o and realign_o still update. Otherwise invalid_o is 0.
- R8: done_o is a single-cycle pulse. It rises 51 clock edges after the edge that accepts start_i on a valid result, and 13 edges after it on an invalid one.
- R9: start_i has no effect while a run is in progress. Between done pulses, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one tracking run (accepted only when idle) |
| smp_we_i | input | 1 | Window sample write enable |
| smp_addr_i | input | 8 | Window sample index |
| smp_data_i | input | 24 | Filtered sample, signed |
| tbl_we_i | input | 1 | Correction table write enable |
| tbl_addr_i | input | 11 | Correction table entry |
| tbl_data_i | input | 16 | Offset in ns, signed |
| done_o | output | 1 | Result strobe, one cycle |
| idx_o | output | 8 | Chosen tracking sample |
| shift_o | output | 9 | Signed window shift request in samples |
| offset_o | output | 16 | Signed sub-sample offset in ns |
| invalid_o | output | 1 | Neighbour difference was zero |
| realign_o | output | 1 | Window realignment requested |

## Verification
A run spends nine cycles scanning the neighbourhood, two fetching the neighbours and one deciding on the divide. A valid run then spends 36 cycles in the divider and three on indexing, lookup and the strobe, for a total of 51 edges. An invalid run jumps straight to the strobe, for a total of 13 edges. The bench counts rising edges from the edge that takes start_i and samples done_o at each falling edge. Each result is compared in that cycle against the bench's own model, and done_o must be low one cycle later. In one run start_i is pulsed while the block is busy, and the bench then watches for a second strobe in the cycles that follow.

// File: rtl/zc_pkg.sv
package zc_pkg;
  typedef enum logic [2:0] {
    ZS_IDLE, ZS_SCAN, ZS_GETB, ZS_GETA, ZS_DIVGO, ZS_DIVWAIT, ZS_LOOK, ZS_FIN
  } zc_state_e;
endpackage

// File: rtl/zc_ram.sv
// Single write port, asynchronous read; used for the sample window and the table.
module zc_ram #(
  parameter int DEPTH = 160,
  parameter int W     = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  assign rdata = (32'(raddr) < DEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/zc_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
module zc_divider #(
  parameter int NW = 36,
  parameter int DW = 25,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          valid,
  output logic [NW-1:0] quot
);
  logic [DW-1:0] rem;
  logic [NW-1:0] acc;
  logic [CW-1:0] cnt;
  logic [DW:0]   trial, reduced;
  logic          fits;

  assign trial   = {rem, acc[NW-1]};
  assign fits    = trial >= {1'b0, divisor};
  assign reduced = trial - {1'b0, divisor};
  assign quot    = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; acc <= '0; cnt <= '0; busy <= 1'b0; valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (start) begin
        rem  <= '0;
        acc  <= dividend;
        cnt  <= CW'(NW);
        busy <= 1'b1;
      end else if (busy) begin
        rem <= fits ? reduced[DW-1:0] : trial[DW-1:0];
        acc <= {acc[NW-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/zc_tracker.sv
module zc_tracker #(
  parameter int N_WIN     = 160,
  parameter int SW        = 24,
  parameter int NOMINAL   = 75,
  parameter int DRIFT_MAX = 10,
  parameter int SRCH      = 4,
  parameter int FRAC      = 12,
  parameter int TBL_N     = 1111,
  parameter int OW        = 16,
  parameter int IDX_ZERO  = 574,
  parameter int IDX_SCALE = 1820,
  localparam int AW       = $clog2(N_WIN),
  localparam int TW       = $clog2(TBL_N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 smp_we_i,
  input  logic [AW-1:0]        smp_addr_i,
  input  logic signed [SW-1:0] smp_data_i,
  input  logic                 tbl_we_i,
  input  logic [TW-1:0]        tbl_addr_i,
  input  logic signed [OW-1:0] tbl_data_i,
  output logic                 done_o,
  output logic [AW-1:0]        idx_o,
  output logic signed [AW:0]   shift_o,
  output logic signed [OW-1:0] offset_o,
  output logic                 invalid_o,
  output logic                 realign_o
);
  import zc_pkg::*;

  localparam int QW     = SW + FRAC;
  localparam int DW     = SW + 1;
  localparam int QCLAMP = 1 << FRAC;
  localparam logic signed [AW:0] NOM_S = (AW+1)'(NOMINAL);
  localparam logic signed [AW:0] LIM_S = (AW+1)'(DRIFT_MAX);

  // Arithmetic helpers
  function automatic logic [SW-1:0] f_mag(input logic signed [SW-1:0] v);
    return v[SW-1] ? SW'(-v) : SW'(v);
  endfunction

  function automatic logic [DW-1:0] f_mag_d(input logic signed [DW-1:0] v);
    return v[DW-1] ? DW'(-v) : DW'(v);
  endfunction

  function automatic logic [TW-1:0] f_tidx(input logic [QW-1:0] qmag, input logic neg);
    logic signed [63:0] qs, p, t;
    qs = (64'(qmag) > 64'(QCLAMP)) ? 64'(QCLAMP) : 64'(qmag);
    if (neg) qs = -qs;
    p = qs * 64'(IDX_SCALE);
    t = 64'(IDX_ZERO) + (p >>> FRAC);
    if (t < 0) return '0;
    if (t > 64'(TBL_N - 1)) return TW'(TBL_N - 1);
    return TW'(t);
  endfunction

  zc_state_e st;
  logic [AW-1:0]        trk, ptr, lo, hi, best_idx, rd_addr;
  logic [SW-1:0]        best_abs;
  logic signed [SW-1:0] fb, fn, fa, rd_data;
  logic signed [DW-1:0] diff_w;
  logic signed [AW:0]   drift_w;
  logic                 realign_w, neg_w, inv_r;
  logic [TW-1:0]        tidx;
  logic signed [OW-1:0] off_r, lut_rd;
  logic                 div_start, div_valid;
  logic [QW-1:0]        quot;

  // Internal events for the checker
  logic div_busy, fsm_busy;
  assign fsm_busy = (st != ZS_IDLE);

  always_comb begin
    int lo_i, hi_i;
    lo_i = int'(trk) - SRCH;
    hi_i = int'(trk) + SRCH;
    if (lo_i < 1) lo_i = 1;
    if (hi_i > N_WIN - 2) hi_i = N_WIN - 2;
    lo = AW'(lo_i);
    hi = AW'(hi_i);
  end

  always_comb begin
    case (st)
      ZS_GETB: rd_addr = best_idx - 1'b1;
      ZS_GETA: rd_addr = best_idx + 1'b1;
      default: rd_addr = ptr;
    endcase
  end

  assign diff_w    = DW'(fa) - DW'(fb);
  assign neg_w     = fn[SW-1] ^ diff_w[DW-1];
  assign div_start = (st == ZS_DIVGO) && (diff_w != '0);
  assign drift_w   = $signed({1'b0, best_idx}) - NOM_S;
  assign realign_w = (drift_w > LIM_S) || (drift_w < -LIM_S);

  zc_ram #(.DEPTH(N_WIN), .W(SW)) u_win (
    .clk(clk), .we(smp_we_i), .waddr(smp_addr_i), .wdata(smp_data_i),
    .raddr(rd_addr), .rdata(rd_data)
  );

  zc_ram #(.DEPTH(TBL_N), .W(OW)) u_lut (
    .clk(clk), .we(tbl_we_i), .waddr(tbl_addr_i), .wdata(tbl_data_i),
    .raddr(tidx), .rdata(lut_rd)
  );

  zc_divider #(.NW(QW), .DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend({f_mag(fn), {FRAC{1'b0}}}), .divisor(f_mag_d(diff_w)),
    .busy(div_busy), .valid(div_valid), .quot(quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ZS_IDLE; trk <= AW'(NOMINAL); ptr <= '0;
      best_idx <= '0; best_abs <= '0; fb <= '0; fn <= '0; fa <= '0;
      inv_r <= 1'b0; tidx <= '0; off_r <= '0;
      done_o <= 1'b0; idx_o <= AW'(NOMINAL); shift_o <= '0;
      offset_o <= '0; invalid_o <= 1'b0; realign_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ZS_IDLE: if (start_i) begin
          st <= ZS_SCAN; ptr <= lo; best_idx <= lo; best_abs <= '1;
        end
        ZS_SCAN: begin
          if (f_mag(rd_data) < best_abs) begin
            best_abs <= f_mag(rd_data);
            best_idx <= ptr;
            fn       <= rd_data;
          end
          if (ptr == hi) st <= ZS_GETB;
          else ptr <= ptr + 1'b1;
        end
        ZS_GETB: begin fb <= rd_data; st <= ZS_GETA; end
        ZS_GETA: begin fa <= rd_data; st <= ZS_DIVGO; end
        ZS_DIVGO: begin
          inv_r <= (diff_w == '0);
          st    <= (diff_w == '0) ? ZS_FIN : ZS_DIVWAIT;
        end
        ZS_DIVWAIT: if (div_valid) begin
          tidx <= f_tidx(quot, neg_w);
          st   <= ZS_LOOK;
        end
        ZS_LOOK: begin off_r <= lut_rd; st <= ZS_FIN; end
        ZS_FIN: begin
          done_o    <= 1'b1;
          idx_o     <= best_idx;
          invalid_o <= inv_r;
          if (!inv_r) offset_o <= off_r;
          realign_o <= realign_w;
          shift_o   <= realign_w ? drift_w : '0;
          trk       <= realign_w ? AW'(NOMINAL) : best_idx;
          st        <= ZS_IDLE;
        end
        default: st <= ZS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/zc_tracker_chk.sv
module zc_tracker_chk #(
  parameter int AW        = 8,
  parameter int NOMINAL   = 75,
  parameter int DRIFT_MAX = 10,
  parameter int OW        = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 done_o,
  input logic [AW-1:0]        idx_o,
  input logic signed [AW:0]   shift_o,
  input logic signed [OW-1:0] offset_o,
  input logic                 invalid_o,
  input logic                 realign_o,
  input logic                 div_busy,
  input logic                 fsm_busy
);
  localparam logic signed [AW:0] NOM_S = (AW+1)'(NOMINAL);
  localparam logic signed [AW:0] LIM_S = (AW+1)'(DRIFT_MAX);
  logic signed [AW:0] drift_c;
  assign drift_c = $signed({1'b0, idx_o}) - NOM_S;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DIV_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> fsm_busy); // R8
  AST_REALIGN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && realign_o) |-> (shift_o == drift_c && (drift_c > LIM_S || drift_c < -LIM_S))); // R5
  AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !realign_o) |-> (shift_o == '0 && drift_c <= LIM_S && drift_c >= -LIM_S)); // R6
  AST_INVALID_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && invalid_o) |-> $stable(offset_o)); // R7
  AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(idx_o) && $stable(offset_o) && $stable(shift_o) && $stable(realign_o) && $stable(invalid_o))); // R9
endmodule

bind zc_tracker zc_tracker_chk #(.AW(AW), .NOMINAL(NOMINAL), .DRIFT_MAX(DRIFT_MAX), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o), .idx_o(idx_o), .shift_o(shift_o),
  .offset_o(offset_o), .invalid_o(invalid_o), .realign_o(realign_o),
  .div_busy(div_busy), .fsm_busy(fsm_busy)
);

// File: tb/sim_zc_tracker.sv
`timescale 1ns/1ps
module sim_zc_tracker;
  localparam int N    = 160;
  localparam int TBLN = 1111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, smp_we_i = 1'b0, tbl_we_i = 1'b0;
  logic [7:0] smp_addr_i = '0;
  logic signed [23:0] smp_data_i = '0;
  logic [10:0] tbl_addr_i = '0;
  logic signed [15:0] tbl_data_i = '0;
  logic done_o, invalid_o, realign_o;
  logic [7:0] idx_o;
  logic signed [8:0] shift_o;
  logic signed [15:0] offset_o;

  always #2 clk = ~clk;

  zc_tracker u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .smp_we_i(smp_we_i), .smp_addr_i(smp_addr_i), .smp_data_i(smp_data_i),
    .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_data_i(tbl_data_i),
    .done_o(done_o), .idx_o(idx_o), .shift_o(shift_o), .offset_o(offset_o),
    .invalid_o(invalid_o), .realign_o(realign_o)
  );

  int checks = 0, fails = 0;
  longint w [N];
  int m_trk = 75;
  longint m_off = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint tbl_val(input int i);
    return 3 * i - 1000;
  endfunction

  // Background window: large alternating values, then the crossing and neighbours.
  task automatic build(input int c, input longint fb, input longint fn, input longint fa);
    for (int i = 0; i < N; i++)
      w[i] = ((i % 2) ? 1 : -1) * (200000 + longint'($urandom % 100000));
    w[c-1] = fb; w[c] = fn; w[c+1] = fa;
  endtask

  task automatic load_window();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      smp_we_i = 1'b1; smp_addr_i = 8'(i); smp_data_i = 24'(w[i]);
    end
    @(negedge clk) smp_we_i = 1'b0;
  endtask

  task automatic round(input string tag, input bit poke);
    int lo, hi, best, lat, n, drift, t, extra;
    longint babs, a, fb, fn, fa, d, q, p, fl, e_off;
    bit inv, rea, seen;
    lo = (m_trk - 4 < 1) ? 1 : m_trk - 4;
    hi = (m_trk + 4 > N - 2) ? N - 2 : m_trk + 4;
    best = lo; babs = 64'h7fffffffffffffff;
    for (int i = lo; i <= hi; i++) begin
      a = (w[i] < 0) ? -w[i] : w[i];
      if (a < babs) begin babs = a; best = i; end
    end
    fb = w[best-1]; fn = w[best]; fa = w[best+1]; d = fa - fb;
    inv = (d == 0);
    e_off = m_off;
    if (!inv) begin
      q = (fn * 4096) / d;
      if (q > 4096) q = 4096;
      if (q < -4096) q = -4096;
      p = q * 1820;
      fl = (p >= 0) ? p / 4096 : -((-p + 4095) / 4096);
      t = 574 + int'(fl);
      if (t < 0) t = 0;
      if (t > TBLN - 1) t = TBLN - 1;
      e_off = tbl_val(t);
    end
    drift = best - 75;
    rea = (drift > 10) || (drift < -10);
    lat = (hi - lo + 1) + (inv ? 4 : 42);
    load_window();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    n = 0; seen = 1'b0;
    while (n < 200 && !seen) begin
      @(posedge clk); n++;
      @(negedge clk);
      start_i = poke && (n == 5);
      if (done_o) seen = 1'b1;
    end
    start_i = 1'b0;
    chk({tag, " R8 latency"}, n, lat);
    chk({tag, " R2 idx"}, idx_o, best);
    chk({tag, " R7 invalid"}, invalid_o, inv);
    chk({tag, " R3 R4 offset"}, offset_o, e_off);
    chk({tag, " R5 realign"}, realign_o, rea);
    chk({tag, " R6 shift"}, shift_o, rea ? drift : 0);
    @(negedge clk);
    chk({tag, " R8 pulse width"}, done_o, 0);
    if (poke) begin
      extra = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (done_o) extra++;
      end
      chk({tag, " R9 start while busy"}, extra, 0);
      chk({tag, " R9 hold idx"}, idx_o, best);
    end
    m_off = e_off;
    m_trk = rea ? 75 : best;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk);
    chk("R1 done", done_o, 0);
    chk("R1 idx", idx_o, 75);
    chk("R1 shift", shift_o, 0);
    chk("R1 offset", offset_o, 0);
    chk("R1 flags", {invalid_o, realign_o}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < TBLN; i++) begin
      @(negedge clk);
      tbl_we_i = 1'b1; tbl_addr_i = 11'(i); tbl_data_i = 16'(tbl_val(i));
    end
    @(negedge clk) tbl_we_i = 1'b0;

    // Drift up to the limit and one past it (R5, R6)
    build(79, -60000, 1200, 70000);   round("up4", 1'b0);
    build(83, -50000, -800, 90000);   round("up8", 1'b0);
    build(85, -40000, 300, 45000);    round("up10", 1'b0);
    build(86, -70000, 2500, 65000);   round("up11", 1'b0);
    // Drift down to -11 (R5)
    build(71, -55000, 900, 52000);    round("dn4", 1'b0);
    build(67, -60000, -1500, 61000);  round("dn8", 1'b0);
    build(64, -45000, 100, 48000);    round("dn11", 1'b0);
    // Zero neighbour difference (R7)
    build(75, 40000, 300, 40000);     round("zero_diff", 1'b0);
    // Quotient and index clamping (R3, R4)
    build(75, 10000, 5000, 10001);    round("clamp_hi", 1'b0);
    build(75, 10000, -5000, 10001);   round("clamp_lo", 1'b0);
    // Tie: equal magnitudes, lower index wins (R2)
    build(76, -90000, 100, 90000);
    w[78] = -100; w[79] = -95000;
    round("tie", 1'b0);
    // Start pulse during a run (R9)
    build(74, -30000, 700, 33000);    round("poke", 1'b1);
    // Random rounds
    for (int r = 0; r < 40; r++) begin
      int c;
      longint fb, fn, fa;
      c  = m_trk + int'($urandom % 9) - 4;
      fn = longint'($urandom % 20000) - 10000;
      fb = -(30000 + longint'($urandom % 200000));
      fa = 30000 + longint'($urandom % 200000);
      if ($urandom % 2) begin fb = -fb; fa = -fa; end
      build(c, fb, fn, fa);
      round("random", 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule